// File: doc/BRIEF.md
# Bus Release and Reclaim Controller

This controller sits on the master side of an external parallel bus that it normally drives. An external device asks for the bus by pulling an active-low request line low. The controller then waits for the internal sequencer to report that its current access has finished. It grants the bus by driving an active-low acknowledge line, and it floats its bus outputs in a fixed order. When the device lets go of the request, the controller takes the bus back in the reverse order.

The outputs are as follows:
- `ack_n`, the acknowledge line.
- `strobe_oe`, the output enable for the control strobes: chip selects, read, write, read/write and cycle start.
- `strobe_idle`, which forces those strobes to their inactive level.
- `adr_dat_oe`, the output enable for the address and data buses.
- `bus_hold`, which tells the internal sequencer not to start a new access.

The request passes through a synchronizer before it is used. The controller only gives the bus back after the request has been seen negated on a minimum number of consecutive sampling edges.

Top module: `bus_yield_ctrl`

## Requirements
- R1: During and right after reset, `ack_n`=1, `strobe_oe`=1, `adr_dat_oe`=1, `strobe_idle`=0 and `bus_hold`=0 (bus owned).
- R2: `req_n` passes through SYNC_STAGES (default 2) flops. With `cycle_done`=1, a fall of `req_n` placed between edges shows as `ack_n`=0 only after the third rising edge.
- R3: While the synchronized request is active and `cycle_done`=0, `ack_n` stays 1 and `bus_hold` is 1.
- R4: On the edge where an active request is sampled together with `cycle_done`=1, `ack_n` goes to 0. In that same cycle `strobe_idle`=1, and both enables stay 1.
- R5: On the edge after `ack_n` falls, `strobe_oe` and `adr_dat_oe` both go to 0. `strobe_idle` is 1 in the cycle before `strobe_oe` falls.
- R6: While released, `ack_n` stays 0 and both enables stay 0.
- R7: `ack_n` returns to 1, and `strobe_oe` to 1, on the edge that samples the NEG_MIN-th (default 2) consecutive negated request. `adr_dat_oe` stays 0 in that cycle.
- R8: One edge later `adr_dat_oe`=1, `bus_hold`=0 and `strobe_idle`=0. `adr_dat_oe` never rises unless `strobe_oe` was already 1 in the previous cycle.
- R9: A request that comes back before NEG_MIN consecutive negated samples restarts the count, and `ack_n` stays 0 with no pulse.
- R10: If the request is withdrawn while the controller waits for `cycle_done`, it returns to the owned state without ever driving `ack_n` low.
- R11: `bus_hold`=0 only when `ack_n`=1 and both enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | External bus request, active low, asynchronous |
| cycle_done | input | 1 | Sequencer reports that no access is in progress or the current one ends now |
| ack_n | output | 1 | Bus grant, active low, always driven |
| strobe_oe | output | 1 | Output enable of the control strobes |
| strobe_idle | output | 1 | Forces the control strobes to their inactive level |
| adr_dat_oe | output | 1 | Output enable of the address and data buses |
| bus_hold | output | 1 | Blocks the sequencer from starting a new access |

## Verification
The hardest case to reach from the ports is a request that returns during the released state after fewer than NEG_MIN negated samples. Because of the synchronizer, the negation must last exactly one clock and be placed so that it lands inside the released window. A directed sequence builds this: it parks the controller in the released state, lifts `req_n` for one cycle, and then holds `ack_n` under watch. Random request pulses of one to six cycles, mixed with a random `cycle_done`, then revisit this case and the withdraw-while-waiting case many times. A cycle model in the bench checks every output on every cycle.

// File: rtl/bus_yield_pkg.sv
package bus_yield_pkg;

  typedef enum logic [2:0] {
    ST_OWN      = 3'd0,
    ST_DRAIN    = 3'd1,
    ST_GRANT    = 3'd2,
    ST_RELEASED = 3'd3,
    ST_RECLAIM  = 3'd4
  } yield_state_e;

  typedef struct packed {
    logic ack_n;
    logic strobe_oe;
    logic strobe_idle;
    logic adr_dat_oe;
    logic bus_hold;
  } yield_out_t;

  // Output pattern held in each state
  function automatic yield_out_t state_outputs(input yield_state_e st);
    yield_out_t o;
    case (st)
      ST_OWN:      o = '{ack_n:1'b1, strobe_oe:1'b1, strobe_idle:1'b0, adr_dat_oe:1'b1, bus_hold:1'b0};
      ST_DRAIN:    o = '{ack_n:1'b1, strobe_oe:1'b1, strobe_idle:1'b0, adr_dat_oe:1'b1, bus_hold:1'b1};
      ST_GRANT:    o = '{ack_n:1'b0, strobe_oe:1'b1, strobe_idle:1'b1, adr_dat_oe:1'b1, bus_hold:1'b1};
      ST_RELEASED: o = '{ack_n:1'b0, strobe_oe:1'b0, strobe_idle:1'b1, adr_dat_oe:1'b0, bus_hold:1'b1};
      ST_RECLAIM:  o = '{ack_n:1'b1, strobe_oe:1'b1, strobe_idle:1'b1, adr_dat_oe:1'b0, bus_hold:1'b1};
      default:     o = '{ack_n:1'b1, strobe_oe:1'b1, strobe_idle:1'b0, adr_dat_oe:1'b1, bus_hold:1'b0};
    endcase
    return o;
  endfunction

  // True when this sample completes the run of negated samples
  function automatic logic run_complete(input int unsigned run_so_far,
                                        input logic        negated_now,
                                        input int unsigned run_needed);
    return negated_now && ((run_so_far + 1) >= run_needed);
  endfunction

endpackage

// File: rtl/bus_yield_sync.sv
module bus_yield_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bus_yield_negrun.sv
module bus_yield_negrun
  import bus_yield_pkg::*;
#(
  parameter int NEG_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic negated,
  output logic neg_met
);
  localparam int CW = (NEG_MIN > 2) ? $clog2(NEG_MIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(NEG_MIN - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run <= '0;
    else if (!count_en || !negated) run <= '0;
    else if (run != LAST)         run <= run + 1'b1;
  end

  assign neg_met = count_en &&
                   run_complete(int'(unsigned'(run)), negated, NEG_MIN);

  // R9
  negrun_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !negated) |=> !neg_met);
endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import bus_yield_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NEG_MIN     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic cycle_done,
  output logic ack_n,
  output logic strobe_oe,
  output logic strobe_idle,
  output logic adr_dat_oe,
  output logic bus_hold
);
  logic         req_n_s;
  logic         req_act;
  logic         neg_met;
  logic         in_released;
  yield_state_e state, state_nx;
  yield_out_t   outs;

  bus_yield_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(req_n), .sync_out(req_n_s)
  );

  assign req_act     = !req_n_s;
  assign in_released = (state == ST_RELEASED);

  bus_yield_negrun #(.NEG_MIN(NEG_MIN)) u_negrun (
    .clk(clk), .rst_n(rst_n), .count_en(in_released),
    .negated(req_n_s), .neg_met(neg_met)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_OWN:      if (req_act) state_nx = cycle_done ? ST_GRANT : ST_DRAIN;
      ST_DRAIN:    if (!req_act) state_nx = ST_OWN;
                   else if (cycle_done) state_nx = ST_GRANT;
      ST_GRANT:    state_nx = ST_RELEASED;
      ST_RELEASED: if (neg_met) state_nx = ST_RECLAIM;
      ST_RECLAIM:  state_nx = ST_OWN;
      default:     state_nx = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_OWN;
    else        state <= state_nx;

  assign outs        = state_outputs(state);
  assign ack_n       = outs.ack_n;
  assign strobe_oe   = outs.strobe_oe;
  assign strobe_idle = outs.strobe_idle;
  assign adr_dat_oe  = outs.adr_dat_oe;
  assign bus_hold    = outs.bus_hold;

  // R5
  float_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |=> (!strobe_oe && !adr_dat_oe));
  // R5
  idle_before_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_oe) |-> $past(strobe_idle));
  // R8
  strobe_before_adr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adr_dat_oe) |-> $past(strobe_oe));
  // R7
  reclaim_on_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(neg_met));
  // R6
  released_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !strobe_oe) |-> !adr_dat_oe);
  // R11
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hold |-> (ack_n && strobe_oe && adr_dat_oe));
  // R10
  drain_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_DRAIN && !$past(req_act)) |-> ack_n);
endmodule

// File: tb/bus_yield_ctrl_tb.sv
module bus_yield_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, req_n, cycle_done;
  logic ack_n, strobe_oe, strobe_idle, adr_dat_oe, bus_hold;
  int   n_checks = 0, n_fail = 0;
  logic cmp_on = 1'b0;

  always #10 clk = ~clk;

  bus_yield_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cycle_done(cycle_done),
    .ack_n(ack_n), .strobe_oe(strobe_oe), .strobe_idle(strobe_idle),
    .adr_dat_oe(adr_dat_oe), .bus_hold(bus_hold)
  );

  // Reference cycle model: 0 own,1 waiting,2 grant,3 released,4 reclaim
  logic m_s1, m_s2;
  int   m_st, m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_st <= 0; m_run <= 0;
    end else begin
      m_s1 <= req_n; m_s2 <= m_s1;
      m_run <= (m_st == 3 && m_s2) ? m_run + 1 : 0;
      case (m_st)
        0: if (!m_s2) m_st <= cycle_done ? 2 : 1;
        1: if (m_s2) m_st <= 0; else if (cycle_done) m_st <= 2;
        2: m_st <= 3;
        3: if (m_s2 && m_run + 1 >= 2) m_st <= 4;
        default: m_st <= 0;
      endcase
    end
  end

  function automatic logic [4:0] exp_outs(input int st);
    // {ack_n, strobe_oe, strobe_idle, adr_dat_oe, bus_hold}
    case (st)
      0: return 5'b11010;
      1: return 5'b11011;
      2: return 5'b01111;
      3: return 5'b00101;
      default: return 5'b11101;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on) begin
    logic [4:0] e;
    e = exp_outs(m_st);
    check("R4 ack_n model",        ack_n,       e[4]);
    check("R5 strobe_oe model",    strobe_oe,   e[3]);
    check("R4 strobe_idle model",  strobe_idle, e[2]);
    check("R8 adr_dat_oe model",   adr_dat_oe,  e[1]);
    check("R11 bus_hold model",    bus_hold,    e[0]);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_fail++; n_checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_n = 1'b1; cycle_done = 1'b0;
    step(3);
    check("R1 ack_n reset", ack_n, 1'b1);
    check("R1 strobe_oe reset", strobe_oe, 1'b1);
    check("R1 adr_dat_oe reset", adr_dat_oe, 1'b1);
    check("R1 strobe_idle reset", strobe_idle, 1'b0);
    check("R1 bus_hold reset", bus_hold, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1 owned after reset", bus_hold, 1'b0);
    cmp_on = 1'b1;

    // R2 latency
    cycle_done = 1'b1; req_n = 1'b0;
    step(2);
    check("R2 ack_n after 2 edges", ack_n, 1'b1);
    step(1);
    check("R2 ack_n after 3 edges", ack_n, 1'b0);
    check("R4 strobe_oe kept in grant", strobe_oe, 1'b1);
    step(1);
    check("R5 strobe_oe floated", strobe_oe, 1'b0);
    check("R5 adr_dat_oe floated", adr_dat_oe, 1'b0);

    // R9: single-cycle negation while released
    step(3);
    check("R6 ack_n held released", ack_n, 1'b0);
    req_n = 1'b1; step(1); req_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(1);
      check("r9_ack_n no pulse", ack_n, 1'b0);
    end
    // R7 / R8 reclaim timing
    req_n = 1'b1;
    step(3);
    check("R7 ack_n after one negated sample", ack_n, 1'b0);
    step(1);
    check("R7 ack_n after second negated sample", ack_n, 1'b1);
    check("R7 strobe_oe back", strobe_oe, 1'b1);
    check("R7 adr_dat_oe still off", adr_dat_oe, 1'b0);
    step(1);
    check("R8 adr_dat_oe back", adr_dat_oe, 1'b1);
    check("R8 bus_hold cleared", bus_hold, 1'b0);
    check("R8 strobe_idle cleared", strobe_idle, 1'b0);

    // R3 / R10: request withdrawn while waiting
    cycle_done = 1'b0; req_n = 1'b0;
    step(4);
    check("R3 ack_n while waiting", ack_n, 1'b1);
    check("R3 bus_hold while waiting", bus_hold, 1'b1);
    req_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R10 ack_n never low", ack_n, 1'b1);
      step(1);
    end
    check("R10 back to owned", bus_hold, 1'b0);

    // Random mix
    for (int k = 0; k < 1500; k++) begin
      req_n = $urandom_range(1, 0);
      for (int j = 0; j < int'($urandom_range(6, 1)); j++) begin
        cycle_done = ($urandom_range(2, 0) != 0);
        step(1);
      end
    end
    req_n = 1'b1; cycle_done = 1'b1;
    step(10);
    check("R11 idle at end", bus_hold, 1'b0);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule